// File: doc/BRIEF.md
# Minutes-Seconds-Hundredths Display Clock

This block keeps running time as minutes, seconds and hundredths of a second and shows it on six active-low seven-segment digits. A prescaler derived from two parameters, the system clock rate and the tick rate, produces a single-cycle enable at 100 Hz. Three cascaded two-digit BCD counters advance on that enable. All state lives in the system clock domain.

Two active-low pushbuttons steer the count. Each one passes through a two-flop synchroniser first. While the preset button is held, the minutes are loaded from an 8-bit switch bus. That bus is read as two BCD digits, and an illegal value is clamped to 59. While the pause button is held, the counters and the prescaler phase freeze. Counting picks up from the same point when the button is released. If both buttons are held, the preset still loads the minutes.

Top module: `mss_clock`

## Requirements
- R1: The hundredths count runs 0 to 99 and wraps to 0. It advances by one every DIV = CLK_HZ/TICK_HZ unpaused clock cycles, and each wrap carries one into the seconds.
- R2: The seconds count runs 0 to 59 and wraps to 0, and each wrap carries one into the minutes.
- R3: The minutes count runs 0 to 59 and wraps from 59 back to 0.
- R4: Digit placement: seg_m1 and seg_m0 show the tens and units of the minutes, seg_s1 and seg_s0 those of the seconds, and seg_h1 and seg_h0 those of the hundredths.
- R5: Each digit is 7 bits and active low, with bit 0 driving segment a and bit 6 driving segment g. A zero is 7'h40, and the values 1 to 9 use the usual lit patterns. A value above 9 drives all bits high.
- R6: While the synchronised preset is active, the minutes take the switch value each cycle. The switch bus is read as tens in sw[7:4] and units in sw[3:0]. Seconds and hundredths keep counting during a preset.
- R7: A switch value whose tens nibble is above 5, or whose units nibble is above 9, loads 59.
- R8: While the synchronised pause is active, no field and no prescaler phase changes. Counting resumes from the held state.
- R9: With both buttons held, the minutes still load from the switches, and the seconds and hundredths stay frozen.
- R10: A button level sampled at a clock edge acts on the state at the second edge after it, through a two-flop synchroniser that reset clears to "released".
- R11: Synchronous reset clears the time to 00:00.00 and zeroes the prescaler, so the first hundredth arrives DIV cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | 8 | Minutes preset as two BCD nibbles |
| key_set_n | input | 1 | Preset button, active low |
| key_hold_n | input | 1 | Pause button, active low |
| seg_m1 | output | 7 | Minutes tens digit, active low |
| seg_m0 | output | 7 | Minutes units digit, active low |
| seg_s1 | output | 7 | Seconds tens digit, active low |
| seg_s0 | output | 7 | Seconds units digit, active low |
| seg_h1 | output | 7 | Hundredths tens digit, active low |
| seg_h0 | output | 7 | Hundredths units digit, active low |

## Verification
The assertions assume the button levels are clean after synchronisation, so bounce is not modelled. They also assume DIV is at least 2, which keeps enable pulses apart. The bench changes buttons and switches only on falling edges and uses a divisor of 4, so both assumptions hold. The bench reaches every switch code, including all of the illegal ones. It also reaches a full minute rollover from 59, plus overlapping presses of both buttons.

// File: rtl/mss_clock.sv
module mss_clock #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sw,
  input  logic       key_set_n,
  input  logic       key_hold_n,
  output logic [6:0] seg_m1,
  output logic [6:0] seg_m0,
  output logic [6:0] seg_s1,
  output logic [6:0] seg_s0,
  output logic [6:0] seg_h1,
  output logic [6:0] seg_h0
);
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [1:0] set_sr, hold_sr;
  logic set_s, hold_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_sr  <= '0;
      hold_sr <= '0;
    end else begin
      set_sr  <= {set_sr[0], ~key_set_n};
      hold_sr <= {hold_sr[0], ~key_hold_n};
    end
  end
  assign set_s  = set_sr[1];
  assign hold_s = hold_sr[1];

  logic [CW-1:0] cnt;
  logic tick;
  assign tick = !hold_s && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!hold_s) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  logic [3:0] h_t, h_u, s_t, s_u, m_t, m_u;
  logic h_end, s_end, m_end;
  assign h_end = (h_t == 4'd9) && (h_u == 4'd9);
  assign s_end = (s_t == 4'd5) && (s_u == 4'd9);
  assign m_end = (m_t == 4'd5) && (m_u == 4'd9);

  logic sw_ok;
  logic [7:0] preset;
  assign sw_ok  = (sw[7:4] <= 4'd5) && (sw[3:0] <= 4'd9);
  assign preset = sw_ok ? sw : 8'h59;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_t <= '0; h_u <= '0;
    end else if (tick) begin
      if (h_u == 4'd9) begin
        h_u <= '0;
        h_t <= (h_t == 4'd9) ? 4'd0 : h_t + 4'd1;
      end else begin
        h_u <= h_u + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_t <= '0; s_u <= '0;
    end else if (tick && h_end) begin
      if (s_u == 4'd9) begin
        s_u <= '0;
        s_t <= (s_t == 4'd5) ? 4'd0 : s_t + 4'd1;
      end else begin
        s_u <= s_u + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_t <= '0; m_u <= '0;
    end else if (set_s) begin
      {m_t, m_u} <= preset;
    end else if (tick && h_end && s_end) begin
      if (m_end) begin
        m_t <= '0; m_u <= '0;
      end else if (m_u == 4'd9) begin
        m_u <= '0;
        m_t <= m_t + 4'd1;
      end else begin
        m_u <= m_u + 4'd1;
      end
    end
  end

  function automatic logic [6:0] dec7(input logic [3:0] d);
    case (d)
      4'd0:    dec7 = 7'h40;
      4'd1:    dec7 = 7'h79;
      4'd2:    dec7 = 7'h24;
      4'd3:    dec7 = 7'h30;
      4'd4:    dec7 = 7'h19;
      4'd5:    dec7 = 7'h12;
      4'd6:    dec7 = 7'h02;
      4'd7:    dec7 = 7'h78;
      4'd8:    dec7 = 7'h00;
      4'd9:    dec7 = 7'h10;
      default: dec7 = 7'h7F;
    endcase
  endfunction

  logic [3:0] dig [6];
  logic [6:0] seg [6];
  assign dig[0] = h_u;
  assign dig[1] = h_t;
  assign dig[2] = s_u;
  assign dig[3] = s_t;
  assign dig[4] = m_u;
  assign dig[5] = m_t;

  for (genvar i = 0; i < 6; i++) begin : g_dec
    assign seg[i] = dec7(dig[i]);
  end

  assign seg_h0 = seg[0];
  assign seg_h1 = seg[1];
  assign seg_s0 = seg[2];
  assign seg_s1 = seg[3];
  assign seg_m0 = seg[4];
  assign seg_m1 = seg[5];
endmodule

module mss_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       set_s,
  input logic       hold_s,
  input logic       tick,
  input logic [7:0] sw,
  input logic [3:0] h_t, h_u, s_t, s_u, m_t, m_u
);
  p_digit_range_r1: assert property (@(posedge clk) disable iff (rst)
    h_t <= 4'd9 && h_u <= 4'd9 && s_t <= 4'd5 && s_u <= 4'd9 && m_t <= 4'd5 && m_u <= 4'd9);

  p_hund_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && h_t == 4'd9 && h_u == 4'd9) |=> (h_t == 4'd0 && h_u == 4'd0));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && h_t == 4'd9 && h_u == 4'd9 && s_t == 4'd5 && s_u == 4'd9) |=> (s_t == 4'd0 && s_u == 4'd0));

  p_min_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_s && tick && {h_t, h_u, s_t, s_u, m_t, m_u} == 24'h995959) |=> ({m_t, m_u} == 8'h00));

  p_load_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (set_s && sw[7:4] <= 4'd5 && sw[3:0] <= 4'd9) |=> ({m_t, m_u} == $past(sw)));

  p_load_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (set_s && (sw[7:4] > 4'd5 || sw[3:0] > 4'd9)) |=> ({m_t, m_u} == 8'h59));

  p_pause_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    (hold_s && !set_s) |=> $stable({h_t, h_u, s_t, s_u, m_t, m_u}));

  p_pause_both_r9: assert property (@(posedge clk) disable iff (rst)
    hold_s |=> $stable({h_t, h_u, s_t, s_u}));

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

bind mss_clock mss_clock_chk u_chk (
  .clk(clk), .rst(rst), .set_s(set_s), .hold_s(hold_s), .tick(tick), .sw(sw),
  .h_t(h_t), .h_u(h_u), .s_t(s_t), .s_u(s_u), .m_t(m_t), .m_u(m_u)
);

// File: tb/sim_mss_clock.sv
module sim_mss_clock;
  localparam int DIV = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] sw = 8'h00;
  logic key_set_n = 1'b1, key_hold_n = 1'b1;
  logic [6:0] seg_m1, seg_m0, seg_s1, seg_s0, seg_h1, seg_h0;
  int checks = 0, fails = 0;
  string tag = "R11";
  bit done = 1'b0;

  always #5 clk = ~clk;

  mss_clock #(.CLK_HZ(DIV * 100), .TICK_HZ(100)) u0 (
    .clk(clk), .rst(rst), .sw(sw), .key_set_n(key_set_n), .key_hold_n(key_hold_n),
    .seg_m1(seg_m1), .seg_m0(seg_m0), .seg_s1(seg_s1), .seg_s0(seg_s0),
    .seg_h1(seg_h1), .seg_h0(seg_h0)
  );

  // reference: total hundredths since 00:00.00, two-stage button delay (R10)
  int tot = 0, ph = 0;
  bit a1 = 0, a2 = 0, b1 = 0, b2 = 0;
  always @(posedge clk) begin
    int t, mv, tn, un;
    bit tk;
    if (rst) begin
      tot <= 0; ph <= 0; a1 <= 0; a2 <= 0; b1 <= 0; b2 <= 0;
    end else begin
      tk = !b2 && (ph == DIV - 1);
      if (!b2) ph <= tk ? 0 : ph + 1;
      t = tot;
      if (tk) t = (t + 1) % 360000;
      if (a2) begin
        tn = sw / 16; un = sw % 16;
        mv = (tn > 5 || un > 9) ? 59 : tn * 10 + un;
        t = mv * 6000 + t % 6000;
      end
      tot <= t;
      a1 <= !key_set_n; a2 <= a1;
      b1 <= !key_hold_n; b2 <= b1;
    end
  end

  // R5: lit-segment masks (bit0=a .. bit6=g), inverted for active-low
  function automatic logic [6:0] pat(input int d);
    logic [6:0] lit;
    case (d)
      0: lit = 7'h3F; 1: lit = 7'h06; 2: lit = 7'h5B; 3: lit = 7'h4F; 4: lit = 7'h66;
      5: lit = 7'h6D; 6: lit = 7'h7D; 7: lit = 7'h07; 8: lit = 7'h7F; default: lit = 7'h6F;
    endcase
    return ~lit;
  endfunction

  task automatic cmp(input string nm, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s R4/R5 %s actual=%h expected=%h (t=%0d)", tag, nm, act, exp, tot);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      int m, s, h;
      m = tot / 6000; s = (tot / 100) % 60; h = tot % 100;
      cmp("seg_m1", seg_m1, pat(m / 10)); cmp("seg_m0", seg_m0, pat(m % 10));
      cmp("seg_s1", seg_s1, pat(s / 10)); cmp("seg_s0", seg_s0, pat(s % 10));
      cmp("seg_h1", seg_h1, pat(h / 10)); cmp("seg_h0", seg_h0, pat(h % 10));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    rst = 1'b0;
    tag = "R11"; run(1);
    checks++;
    if (seg_h0 !== 7'h40 || seg_m1 !== 7'h40) begin
      fails++; $display("FAIL R11 reset actual=%h/%h expected=40/40", seg_m1, seg_h0);
    end
    tag = "R1"; run(700);
    tag = "R2"; run(600);
    tag = "R8"; key_hold_n = 1'b0; run(37); key_hold_n = 1'b1; run(50);
    tag = "R6"; sw = 8'h42; key_set_n = 1'b0; run(5); key_set_n = 1'b1; run(20);
    tag = "R7";
    for (int v = 0; v < 256; v++) begin
      sw = 8'(v); key_set_n = 1'b0; run(3); key_set_n = 1'b1; run(1);
    end
    tag = "R9"; sw = 8'h17; key_hold_n = 1'b0; key_set_n = 1'b0; run(20);
    key_set_n = 1'b1; run(5); key_hold_n = 1'b1; run(10);
    tag = "R10"; key_hold_n = 1'b0; run(1); key_hold_n = 1'b1; run(9);
    tag = "R3"; sw = 8'h59; key_set_n = 1'b0; run(4); key_set_n = 1'b1; run(24200);
    checks++;
    if (seg_m1 !== 7'h40) begin
      fails++; $display("FAIL R3 minute wrap actual=%h expected=40", seg_m1);
    end
    tag = "R11"; rst = 1'b1; run(2); rst = 1'b0; run(DIV + 3);
    checks++;
    if (seg_h0 !== pat(1)) begin
      fails++; $display("FAIL R11 first tick actual=%h expected=%h", seg_h0, pat(1));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule